// File: doc/BRIEF.md
# External Pin Interrupt Trigger Unit

This block watches 24 asynchronous pin inputs and turns selected conditions on them into interrupt requests for a downstream interrupt controller. Every pin has its own 2-bit function field, and only the interrupt function value lets the pin raise requests. Every pin also has its own 3-bit trigger field that picks a low level, a high level, a falling edge, a rising edge, or either edge.

All pins pass through a two-stage synchronizer. Edges are found by comparing the newest synchronized sample with the sample one cycle older. Pins 0 to 3 feed their trigger results straight to four dedicated request outputs. Pins 4 to 23 set sticky pending bits, which software clears by writing ones. A mask register removes pending pins from the request lines. The unmasked pending bits are then ORed into two composite lines: one for pins 4 to 7 and one for pins 8 to 23.

Top module: `ext_pin_irq_unit`

## Requirements
- R1: A pin raises no request, pending or direct, unless its 2-bit function field (bits 2i+1:2i of `func_sel`) equals 2'b10.
- R2: The synchronizer stages reset to low. A level on a pin reaches the trigger logic after two rising clock edges. If a pin is driven high before edge k, `direct_irq` shows it after edge k+1 and not after edge k.
- R3: Trigger code 3'b000 (bits 3i+2:3i of `trig_mode`) fires on every cycle in which the synchronized pin is low.
- R4: Trigger code 3'b001 fires on every cycle in which the synchronized pin is high.
- R5: Trigger codes 3'b010 and 3'b011 fire for exactly one cycle when the synchronized pin goes from high to low.
- R6: Trigger codes 3'b100 and 3'b101 fire for exactly one cycle when the synchronized pin goes from low to high.
- R7: Trigger codes 3'b110 and 3'b111 fire for one cycle on either transition.
- R8: For pins 4 to 23, a firing trigger sets the pin's bit in `pend_q` on the next edge. A one in `pend_clr` clears the bit. A set on the same edge wins over a clear, so a held level re-arms the bit at once.
- R9: After reset all pending bits are 0. Bits 3:0 of `pend_q` always read 0.
- R10: After reset all mask bits are 1. A cycle with `mask_we` high loads `mask_wdata` into `mask_q`. A pending pin with its mask bit at 1 does not reach any composite line.
- R11: `comp_lo` is the OR of (pending AND NOT mask) over pins 4 to 7. `comp_hi` is the same OR over pins 8 to 23. Both follow the registers with no added delay.
- R12: `direct_irq[3:0]` shows the trigger result for pins 0 to 3 in the same cycle, with no pending or mask stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | 24 | Asynchronous pin levels |
| func_sel | input | 48 | 2-bit function field per pin; 2'b10 enables interrupts |
| trig_mode | input | 72 | 3-bit trigger code per pin |
| pend_clr | input | 20 | Write-one-to-clear strobes for pending bits of pins 23:4 |
| mask_we | input | 1 | Load enable for the mask register |
| mask_wdata | input | 20 | New mask value for pins 23:4 |
| pend_q | output | 24 | Pending bits; bits 3:0 read 0 |
| mask_q | output | 20 | Mask bits for pins 23:4 |
| direct_irq | output | 4 | Trigger results of pins 3:0 |
| comp_lo | output | 1 | Composite request for pins 7:4 |
| comp_hi | output | 1 | Composite request for pins 23:8 |

## Verification
A wrong synchronizer or edge-reference register shows up as `direct_irq` pulses one cycle early, one cycle late, or missing. For the upper pins the same fault shows as a pending bit that sets on the wrong edge, and the bench sees it one edge later. A corrupted pending or mask bit shows at the ports at once: `pend_q` and `mask_q` are read every cycle. The fault also flips `comp_lo` or `comp_hi` in the same cycle, unless the mask hides it. The bench sweeps every pin through every function value and every trigger code. It compares all outputs after each edge against a cycle model built from the requirements, so any wrong state is reported within one cycle of the point where it becomes visible.

// File: rtl/ext_irq_pkg.sv
// Shared constants, types and trigger evaluation for the pin interrupt unit.
// Assumes pin samples handed to trig_eval are already synchronized.
package ext_irq_pkg;

    localparam int FUNC_W = 2;
    localparam int MODE_W = 3;
    localparam logic [FUNC_W-1:0] FUNC_IRQ = 2'b10;

    // Upper two bits of a trigger code pick the kind of condition.
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_RISE  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_kind_e;

    // Returns 1 when the condition chosen by mode holds for the current
    // synchronized sample cur and the sample one cycle older, prev.
    function automatic logic trig_eval(input logic [MODE_W-1:0] mode,
                                       input logic cur,
                                       input logic prev);
        trig_kind_e kind;
        logic       fire;
        kind = trig_kind_e'(mode[MODE_W-1:1]);
        case (kind)
            TRIG_LEVEL: fire = mode[0] ? cur : !cur;
            TRIG_FALL:  fire = prev && !cur;
            TRIG_RISE:  fire = !prev && cur;
            default:    fire = prev ^ cur;
        endcase
        return fire;
    endfunction

endpackage

// File: rtl/ext_pin_sync.sv
// Two-flop synchronizer plus one history stage for each pin.
// cur_o is the settled sample; prev_o is cur_o delayed by one clock.
// Assumes pins may change at any time relative to clk.
module ext_pin_sync #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;
    logic             hist_ok_q;

    // Shift the pin levels through the capture, settle and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    // Marks that a full cycle has passed since reset, so $past has a meaning.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok_q <= 1'b0;
        else        hist_ok_q <= 1'b1;
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

    // R2: the edge reference is exactly the settled sample of the cycle before.
    a_r2_history_lags_one: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok_q |-> (prev_o == $past(cur_o)));

    // R2: the settled sample is the captured level of the cycle before.
    a_r2_settle_two_stages: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok_q |-> (cur_o == $past(meta_q)));

endmodule

// File: rtl/ext_trig_detect.sv
// Per-pin trigger evaluation: function gating and the 3-bit trigger code.
// Pure combinational; assumes its inputs come from ext_pin_sync.
module ext_trig_detect
    import ext_irq_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0]        cur_i,
    input  logic [WIDTH-1:0]        prev_i,
    input  logic [FUNC_W*WIDTH-1:0] func_sel_i,
    input  logic [MODE_W*WIDTH-1:0] trig_mode_i,
    output logic [WIDTH-1:0]        hit_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic [FUNC_W-1:0] fsel;
        logic [MODE_W-1:0] tmode;
        assign fsel  = func_sel_i[FUNC_W*i +: FUNC_W];
        assign tmode = trig_mode_i[MODE_W*i +: MODE_W];

        // A pin fires only when configured as an interrupt line and its condition holds.
        always_comb begin
            hit_o[i] = (fsel == FUNC_IRQ) && trig_eval(tmode, cur_i[i], prev_i[i]);
        end
    end

endmodule

// File: rtl/ext_pend_mask.sv
// Sticky pending bits, mask register and composite OR for the upper pins.
// Pins LOW_PIN..SPLIT-1 form the low group, SPLIT..HIGH_PIN the high group.
// Assumes hit_i is a per-cycle trigger result for each upper pin.
module ext_pend_mask #(
    parameter int NUM_PINS    = 24,
    parameter int DIRECT_PINS = 4,
    parameter int GROUP_SPLIT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:DIRECT_PINS] hit_i,
    input  logic [NUM_PINS-1:DIRECT_PINS] clr_i,
    input  logic                          mask_we_i,
    input  logic [NUM_PINS-1:DIRECT_PINS] mask_wdata_i,
    output logic [NUM_PINS-1:DIRECT_PINS] pend_o,
    output logic [NUM_PINS-1:DIRECT_PINS] mask_o,
    output logic                          comp_lo_o,
    output logic                          comp_hi_o
);

    logic [NUM_PINS-1:DIRECT_PINS] pend_q;
    logic [NUM_PINS-1:DIRECT_PINS] mask_q;
    logic [NUM_PINS-1:DIRECT_PINS] live;

    for (genvar i = DIRECT_PINS; i < NUM_PINS; i++) begin : g_bit
        // Hold a pending bit until cleared; a new hit on the same edge keeps it set.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= (pend_q[i] && !clr_i[i]) || hit_i[i];
        end

        // R8: a hit is always recorded on the next edge.
        a_r8_hit_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i[i] |=> pend_o[i]);

        // R8: a pending bit drops only through a clear strobe.
        a_r8_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !clr_i[i]) |=> pend_o[i]);

        // R8: a pending bit rises only through a hit.
        a_r8_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_o[i] && !hit_i[i]) |=> !pend_o[i]);
    end

    // Load the whole mask on a write strobe; everything starts masked.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_wdata_i;
    end

    // Gate pending bits by the mask and reduce each group to one request.
    always_comb begin
        live      = pend_q & ~mask_q;
        comp_lo_o = |live[GROUP_SPLIT-1:DIRECT_PINS];
        comp_hi_o = |live[NUM_PINS-1:GROUP_SPLIT];
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R10: with every pin masked neither composite line may be raised.
    a_r10_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_o) |-> (!comp_lo_o && !comp_hi_o));

    // R11: the high line needs some pending pin in its range.
    a_r11_hi_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        comp_hi_o |-> (pend_o[NUM_PINS-1:GROUP_SPLIT] != '0));

    // R11: the low line needs some pending pin in its range.
    a_r11_lo_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        comp_lo_o |-> (pend_o[GROUP_SPLIT-1:DIRECT_PINS] != '0));

endmodule

// File: rtl/ext_pin_irq_unit.sv
// Top of the external pin interrupt unit. Synchronizes the pins, evaluates
// each pin's trigger, routes low pins to direct outputs and upper pins
// through pending/mask into two composite requests.
// Assumes DIRECT_PINS < GROUP_SPLIT < NUM_PINS.
module ext_pin_irq_unit
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int DIRECT_PINS = 4,
    parameter int GROUP_SPLIT = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:0]           pin_in,
    input  logic [FUNC_W*NUM_PINS-1:0]    func_sel,
    input  logic [MODE_W*NUM_PINS-1:0]    trig_mode,
    input  logic [NUM_PINS-1:DIRECT_PINS] pend_clr,
    input  logic                          mask_we,
    input  logic [NUM_PINS-1:DIRECT_PINS] mask_wdata,
    output logic [NUM_PINS-1:0]           pend_q,
    output logic [NUM_PINS-1:DIRECT_PINS] mask_q,
    output logic [DIRECT_PINS-1:0]        direct_irq,
    output logic                          comp_lo,
    output logic                          comp_hi
);

    logic [NUM_PINS-1:0]           cur;
    logic [NUM_PINS-1:0]           prev;
    logic [NUM_PINS-1:0]           hit;
    logic [NUM_PINS-1:DIRECT_PINS] pend_up;

    ext_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_raw(pin_in),
        .cur_o  (cur),
        .prev_o (prev)
    );

    ext_trig_detect #(.WIDTH(NUM_PINS)) u_detect (
        .cur_i      (cur),
        .prev_i     (prev),
        .func_sel_i (func_sel),
        .trig_mode_i(trig_mode),
        .hit_o      (hit)
    );

    ext_pend_mask #(
        .NUM_PINS   (NUM_PINS),
        .DIRECT_PINS(DIRECT_PINS),
        .GROUP_SPLIT(GROUP_SPLIT)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit[NUM_PINS-1:DIRECT_PINS]),
        .clr_i       (pend_clr),
        .mask_we_i   (mask_we),
        .mask_wdata_i(mask_wdata),
        .pend_o      (pend_up),
        .mask_o      (mask_q),
        .comp_lo_o   (comp_lo),
        .comp_hi_o   (comp_hi)
    );

    // Dedicated pins bypass pending and mask; their field bits read zero.
    always_comb begin
        direct_irq = hit[DIRECT_PINS-1:0];
        pend_q     = {pend_up, {DIRECT_PINS{1'b0}}};
    end

    for (genvar i = 0; i < DIRECT_PINS; i++) begin : g_direct_chk
        // R1: a pin not set to the interrupt function stays silent.
        a_r1_direct_needs_func: assert property (@(posedge clk) disable iff (!rst_n)
            (func_sel[FUNC_W*i +: FUNC_W] != FUNC_IRQ) |-> !direct_irq[i]);

        // R5: a falling-edge pin fires only when the synchronizer shows a drop.
        a_r5_fall_matches_sync: assert property (@(posedge clk) disable iff (!rst_n)
            ((trig_mode[MODE_W*i+1 +: 2] == 2'b01) && direct_irq[i]) |-> (prev[i] && !cur[i]));

        // R6: a rising-edge pin fires only when the synchronizer shows a rise.
        a_r6_rise_matches_sync: assert property (@(posedge clk) disable iff (!rst_n)
            ((trig_mode[MODE_W*i+1 +: 2] == 2'b10) && direct_irq[i]) |-> (!prev[i] && cur[i]));
    end

endmodule

// File: tb/sim_ext_pin_irq_unit.sv
module sim_ext_pin_irq_unit;

    localparam int N = 24;
    localparam int D = 4;
    localparam int S = 8;
    localparam logic [11:0] WAVE = 12'b0011_1010_0110;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     pin_in;
    logic [2*N-1:0]   func_sel;
    logic [3*N-1:0]   trig_mode;
    logic [N-1:D]     pend_clr;
    logic             mask_we;
    logic [N-1:D]     mask_wdata;
    logic [N-1:0]     pend_q;
    logic [N-1:D]     mask_q;
    logic [D-1:0]     direct_irq;
    logic             comp_lo;
    logic             comp_hi;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench-side model state derived from the requirements.
    logic [N-1:0] m1, m2, m3;
    logic [N-1:D] mpend, mmask;
    logic [1:0]   fcfg [N];
    logic [2:0]   tcfg [N];
    logic [31:0]  lfsr = 32'h1ACE_5EED;

    always #10 clk = ~clk;

    ext_pin_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .func_sel(func_sel),
        .trig_mode(trig_mode), .pend_clr(pend_clr), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .pend_q(pend_q), .mask_q(mask_q),
        .direct_irq(direct_irq), .comp_lo(comp_lo), .comp_hi(comp_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // Expected trigger results per R1 and R3..R7 from settled/previous samples.
    function automatic logic [N-1:0] exp_hit(input logic [N-1:0] c, input logic [N-1:0] p);
        logic [N-1:0] h;
        for (int i = 0; i < N; i++) begin
            case (tcfg[i])
                3'b000:         h[i] = !c[i];
                3'b001:         h[i] = c[i];
                3'b010, 3'b011: h[i] = p[i] && !c[i];
                3'b100, 3'b101: h[i] = !p[i] && c[i];
                default:        h[i] = p[i] ^ c[i];
            endcase
            h[i] = h[i] && (fcfg[i] == 2'b10);
        end
        return h;
    endfunction

    function automatic string mode_tag(input logic [1:0] f, input logic [2:0] m);
        if (f != 2'b10) return "R1";
        case (m[2:1])
            2'b00:   return m[0] ? "R4" : "R3";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // One clock of stimulus with full comparison of every output afterwards.
    task automatic step(input logic [N-1:0] pins, input logic [N-1:D] clr,
                        input logic mwe, input logic [N-1:D] mwd, input string mt);
        logic [N-1:0] h;
        logic [N-1:D] live;
        @(negedge clk);
        pin_in = pins; pend_clr = clr; mask_we = mwe; mask_wdata = mwd;
        for (int i = 0; i < N; i++) begin
            func_sel[2*i +: 2]  = fcfg[i];
            trig_mode[3*i +: 3] = tcfg[i];
        end
        h = exp_hit(m2, m3);
        @(posedge clk);
        mpend = (mpend & ~clr) | h[N-1:D];
        if (mwe) mmask = mwd;
        m3 = m2; m2 = m1; m1 = pins;
        #2;
        h = exp_hit(m2, m3);
        live = mpend & ~mmask;
        chk({"R12/", mt}, 32'(direct_irq), 32'(h[D-1:0]));
        chk({"R8/", mt},  32'(pend_q[N-1:D]), 32'(mpend));
        chk("R9",         32'(pend_q[D-1:0]), 32'd0);
        chk("R10",        32'(mask_q), 32'(mmask));
        chk("R11 lo",     32'(comp_lo), 32'(|live[S-1:D]));
        chk("R11 hi",     32'(comp_hi), 32'(|live[N-1:S]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pins;
        logic [N-1:D] mw;
        rst_n = 1'b0; pin_in = '0; func_sel = '0; trig_mode = '0;
        pend_clr = '0; mask_we = 1'b0; mask_wdata = '0;
        m1 = '0; m2 = '0; m3 = '0; mpend = '0; mmask = '1;
        for (int i = 0; i < N; i++) begin fcfg[i] = 2'b00; tcfg[i] = 3'b000; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9 / R10 reset state
        chk("R9 reset pending", 32'(pend_q), 32'd0);
        chk("R10 reset mask", 32'(mask_q), 32'(mmask));

        // R2 latency: pin 0 high-level, driven high before edge k.
        fcfg[0] = 2'b10; tcfg[0] = 3'b001;
        step(24'h1, '0, 1'b0, '0, "R4");
        chk("R2 after first edge", 32'(direct_irq[0]), 32'd0);
        step(24'h1, '0, 1'b0, '0, "R4");
        chk("R2 after second edge", 32'(direct_irq[0]), 32'd1);
        step(24'h0, '0, 1'b0, '0, "R4");
        fcfg[0] = 2'b00;

        // Sweep every pin through every function value and trigger code.
        for (int p = 0; p < N; p++) begin
            for (int f = 0; f < 4; f++) begin
                for (int m = 0; m < 8; m++) begin
                    string mt;
                    for (int i = 0; i < N; i++) begin
                        fcfg[i] = 2'b00;
                        tcfg[i] = 3'((i * 3) % 8);
                    end
                    fcfg[p] = 2'(f);
                    tcfg[p] = 3'(m);
                    mt = mode_tag(2'(f), 3'(m));
                    for (int k = 0; k < 12; k++) begin
                        logic [N-1:D] clr;
                        logic         we;
                        pins = N'(next_rand());
                        pins[p] = WAVE[k];
                        clr = '0; we = 1'b0; mw = mmask;
                        if (k == 0) begin
                            clr = '1; we = 1'b1; mw = (N-D)'(next_rand());
                            if (p >= D) mw[p] = 1'(f ^ m);
                        end
                        if (k == 4 && p >= D) begin
                            we = 1'b1; mw = mmask; mw[p] = !mmask[p];
                        end
                        if (k == 7 && p >= D) clr[p] = 1'b1;
                        if (k == 10) clr = (N-D)'(next_rand());
                        step(pins, clr, we, mw, mt);
                    end
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule